// File: doc/BRIEF.md
# Unsigned Bitfield Move Unit

This execution unit moves a contiguous run of bits from a source word into a zero-filled result. It works on a 64-bit or a 32-bit operand. Two 6-bit immediates steer it: a rotate amount and a leftmost bit number. When the leftmost bit number is at least the rotate amount, the unit extracts a field and right-aligns it. Otherwise it takes the low bits of the source and inserts them higher up in the result. Both behaviours share one datapath: the operand is rotated right, then ANDed with two computed masks.

The unit also checks the size select, the N bit and the immediates. An illegal combination raises an undefined-encoding flag and forces the data to zero. The result and the flag leave through one register stage. Latency is one clock whatever the operand values. There is no handshake: every clock captures the inputs presented before it.

Top module: `bitfield_move_unit`

## Requirements
- R1: With `wide_i`=1, `nbit_i`=1 and `top_i` >= `rot_i`, `res_o` holds source bits `rot_i`..`top_i`, right-aligned at bit 0.
- R2: When `top_i` < `rot_i`, the low (`top_i`+1) bits of the source appear in `res_o` starting at bit position (size - `rot_i`), where size is 64 when `wide_i`=1 and 32 when `wide_i`=0.
- R3: Every result bit outside the moved field is zero, in both modes and both sizes.
- R4: With `wide_i`=0, only source bits 31..0 affect the result, and `res_o[63:32]` is zero.
- R5: `wide_i`=1 with `nbit_i`=0 raises `undef_o`.
- R6: `wide_i`=0 with any of `nbit_i`, `rot_i[5]` or `top_i[5]` set raises `undef_o`. A legal encoding leaves `undef_o` low.
- R7: Whenever `undef_o` is high, `res_o` is zero.
- R8: Results and flags appear exactly one clock edge after their inputs are captured, for every data value. Until that edge the previous output holds.
- R9: A synchronous active-high reset clears `res_o` and `undef_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 64 | Source operand |
| wide_i | input | 1 | 1 selects 64-bit operation, 0 selects 32-bit |
| nbit_i | input | 1 | N bit of the encoding |
| rot_i | input | 6 | Rotate amount |
| top_i | input | 6 | Leftmost source bit number |
| res_o | output | 64 | Registered zero-extended result |
| undef_o | output | 1 | Registered undefined-encoding flag |

## Verification
Every result and flag is due at the first rising edge after its inputs are applied. The bench drives inputs just after a falling edge and compares the outputs at the next falling edge, half a period after the capturing edge. For the latency check, the bench changes the inputs and samples again before the next rising edge, so the previous value must still be present. The sweep covers every rotate/leftmost pair in both sizes, with several operand patterns each, against an arithmetic shift-and-mask model.

// File: rtl/bfm_pkg.sv
package bfm_pkg;

    localparam int unsigned BFM_XW = 64;
    localparam int unsigned BFM_AW = $clog2(BFM_XW);

    typedef enum logic {
        MODE_EXTRACT = 1'b0,
        MODE_INSERT  = 1'b1
    } bfm_mode_e;

    typedef struct packed {
        logic              wide;
        logic              nbit;
        logic [BFM_AW-1:0] rot;
        logic [BFM_AW-1:0] top;
    } bfm_ctl_t;

    typedef struct packed {
        logic [BFM_XW-1:0] data;
        logic              undef;
    } bfm_res_t;

    function automatic bfm_mode_e bfm_mode_of(input bfm_ctl_t c);
        return (c.top < c.rot) ? MODE_INSERT : MODE_EXTRACT;
    endfunction

    function automatic logic bfm_is_illegal(input bfm_ctl_t c);
        if (c.wide)
            return !c.nbit;
        return c.nbit | c.rot[BFM_AW-1] | c.top[BFM_AW-1];
    endfunction

endpackage

// File: rtl/bfm_legal.sv
module bfm_legal
    import bfm_pkg::*;
(
    input  bfm_ctl_t  ctl,
    output logic      illegal,
    output bfm_mode_e mode
);
    always_comb begin
        illegal = bfm_is_illegal(ctl);
        mode    = bfm_mode_of(ctl);
    end
endmodule

// File: rtl/bfm_rotr.sv
module bfm_rotr #(
    parameter int DW = 64,
    localparam int AW = $clog2(DW)
) (
    input  logic [DW-1:0] din,
    input  logic [AW-1:0] amt,
    output logic [DW-1:0] dout
);
    logic [DW-1:0] stg [0:AW];

    assign stg[0] = din;

    for (genvar k = 0; k < AW; k++) begin : g_stage
        localparam int SH = 1 << k;
        assign stg[k+1] = amt[k] ? {stg[k][SH-1:0], stg[k][DW-1:SH]} : stg[k];
    end

    assign dout = stg[AW];
endmodule

// File: rtl/bfm_masks.sv
module bfm_masks
    import bfm_pkg::*;
#(
    parameter int DW = 64,
    localparam int AW = $clog2(DW)
) (
    input  logic          wide,
    input  bfm_mode_e     mode,
    input  logic [AW-1:0] rot,
    input  logic [AW-1:0] top,
    output logic [DW-1:0] wmask,
    output logic [DW-1:0] tmask
);
    always_comb begin
        int sz;
        int r;
        int s;
        int lo;
        int idx;
        sz = wide ? DW : DW / 2;
        r  = int'(rot);
        s  = int'(top);
        lo = sz - r;
        for (int i = 0; i < DW; i++) begin
            // source bit that lands on result bit i after rotation
            idx = i + r;
            if (idx >= sz) idx = idx - sz;
            wmask[i] = (i < sz) && (idx <= s);
            if (mode == MODE_EXTRACT)
                tmask[i] = (i < sz) && (i <= s - r);
            else
                tmask[i] = (i < sz) && (i >= lo) && (i <= lo + s);
        end
    end
endmodule

// File: rtl/bitfield_move_unit.sv
module bitfield_move_unit
    import bfm_pkg::*;
#(
    parameter int DW = 64,
    localparam int AW = $clog2(DW),
    localparam int HW = DW / 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] src_i,
    input  logic          wide_i,
    input  logic          nbit_i,
    input  logic [AW-1:0] rot_i,
    input  logic [AW-1:0] top_i,
    output logic [DW-1:0] res_o,
    output logic          undef_o
);
    bfm_ctl_t      ctl;
    bfm_mode_e     mode;
    logic          illegal;
    logic [DW-1:0] opnd;
    logic [DW-1:0] rotated;
    logic [DW-1:0] wmask;
    logic [DW-1:0] tmask;
    logic [DW-1:0] moved;
    logic [DW-1:0] res_q;
    logic          undef_q;

    always_comb begin
        ctl.wide = wide_i;
        ctl.nbit = nbit_i;
        ctl.rot  = rot_i;
        ctl.top  = top_i;
    end

    bfm_legal u_legal (
        .ctl     (ctl),
        .illegal (illegal),
        .mode    (mode)
    );

    // narrow mode: duplicate the low half so a full-width rotate acts as a half-width one
    assign opnd = wide_i ? src_i : {src_i[HW-1:0], src_i[HW-1:0]};

    bfm_rotr #(.DW(DW)) u_rotr (
        .din  (opnd),
        .amt  (rot_i),
        .dout (rotated)
    );

    bfm_masks #(.DW(DW)) u_masks (
        .wide  (wide_i),
        .mode  (mode),
        .rot   (rot_i),
        .top   (top_i),
        .wmask (wmask),
        .tmask (tmask)
    );

    assign moved = illegal ? '0 : (rotated & wmask & tmask);

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q   <= '0;
            undef_q <= 1'b0;
        end else begin
            res_q   <= moved;
            undef_q <= illegal;
        end
    end

    assign res_o   = res_q;
    assign undef_o = undef_q;

    // R7: a flagged encoding never carries data
    p_undef_zero_r7: assert property (@(posedge clk) disable iff (rst)
        undef_o |-> (res_o == '0));

    // R5: wide mode without N is undefined
    p_wide_no_n_r5: assert property (@(posedge clk) disable iff (rst)
        (wide_i && !nbit_i) |=> undef_o);

    // R6: narrow mode with N or an immediate above 31 is undefined
    p_narrow_bad_r6: assert property (@(posedge clk) disable iff (rst)
        (!wide_i && (nbit_i || rot_i[AW-1] || top_i[AW-1])) |=> undef_o);

    // R6: legal wide encoding is accepted
    p_wide_ok_r6: assert property (@(posedge clk) disable iff (rst)
        (wide_i && nbit_i) |=> !undef_o);

    // R4: narrow results leave the upper half clear
    p_narrow_upper_r4: assert property (@(posedge clk) disable iff (rst)
        !wide_i |=> (res_o[DW-1:HW] == '0));

    // R1: extract with zero rotate keeps source bit 0 in place
    p_extract_lsb_r1: assert property (@(posedge clk) disable iff (rst)
        (wide_i && nbit_i && rot_i == '0) |=> (res_o[0] == $past(src_i[0])));
endmodule

// File: tb/test_bitfield_move_unit.sv
`timescale 1ns/1ps
module test_bitfield_move_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic [63:0] src;
    logic        wide;
    logic        nbit;
    logic [5:0]  rot;
    logic [5:0]  top;
    logic [63:0] res;
    logic        undef;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    bitfield_move_unit i_bitfield_move_unit (
        .clk     (clk),
        .rst     (rst),
        .src_i   (src),
        .wide_i  (wide),
        .nbit_i  (nbit),
        .rot_i   (rot),
        .top_i   (top),
        .res_o   (res),
        .undef_o (undef)
    );

    function automatic logic [63:0] ones(input int k);
        if (k >= 64) return '1;
        if (k <= 0) return '0;
        return (64'd1 << k) - 64'd1;
    endfunction

    function automatic logic [63:0] model(input logic [63:0] s_in, input bit w,
                                          input int r, input int s);
        int sz;
        logic [63:0] v;
        sz = w ? 64 : 32;
        v  = s_in & ones(sz);
        if (s >= r) return (v >> r) & ones(s - r + 1);
        return ((v & ones(s + 1)) << (sz - r)) & ones(sz);
    endfunction

    function automatic logic [63:0] pattern(input int k);
        logic [63:0] p;
        p = 64'h9E37_79B9_7F4A_7C15 * 64'(k + 1);
        return p ^ {p[31:0], p[63:32]} ^ 64'(k * 977);
    endfunction

    task automatic check(input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (wide=%0d n=%0d rot=%0d top=%0d)",
                     req, act, exp, wide, nbit, rot, top);
        end
    endtask

    task automatic apply(input logic [63:0] s_in, input bit w, input bit n,
                         input int r, input int s);
        src  = s_in;
        wide = w;
        nbit = n;
        rot  = 6'(r);
        top  = 6'(s);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] prev;
        logic [63:0] d;
        rst = 1'b1; src = '1; wide = 1'b1; nbit = 1'b1; rot = 6'd0; top = 6'd63;
        @(negedge clk);
        @(negedge clk);
        // R9: reset clears outputs
        check("R9 res", res, '0);
        check("R9 undef", 64'(undef), 64'd0);
        rst = 1'b0;

        // R1 R2 R3: every wide pair, legal encoding
        for (int r = 0; r < 64; r++) begin
            for (int s = 0; s < 64; s++) begin
                d = pattern(r * 64 + s);
                apply(d, 1'b1, 1'b1, r, s);
                check(s >= r ? "R1 R3 wide extract" : "R2 R3 wide insert",
                      res, model(d, 1'b1, r, s));
                check("R6 legal wide", 64'(undef), 64'd0);
            end
        end

        // R4 R1 R2: every narrow pair, upper source bits must not leak
        for (int p = 0; p < 3; p++) begin
            for (int r = 0; r < 32; r++) begin
                for (int s = 0; s < 32; s++) begin
                    d = (p == 0) ? pattern(r * 32 + s + 5000) :
                        (p == 1) ? {32'hFFFF_FFFF, 32'h0} : 64'hFFFF_FFFF_FFFF_FFFF;
                    apply(d, 1'b0, 1'b0, r, s);
                    check("R4 narrow", res, model(d, 1'b0, r, s));
                end
            end
        end

        // R5 R7: wide with N clear
        for (int k = 0; k < 16; k++) begin
            apply('1, 1'b1, 1'b0, k * 4, 63 - k);
            check("R5 undef", 64'(undef), 64'd1);
            check("R7 zero data", res, '0);
        end

        // R6 R7: narrow illegal forms
        for (int k = 0; k < 16; k++) begin
            apply('1, 1'b0, 1'b1, k, k + 3);
            check("R6 narrow n", 64'(undef), 64'd1);
            check("R7 zero data", res, '0);
            apply('1, 1'b0, 1'b0, 32 + k, k);
            check("R6 narrow rot5", 64'(undef), 64'd1);
            check("R7 zero data", res, '0);
            apply('1, 1'b0, 1'b0, k, 32 + k);
            check("R6 narrow top5", 64'(undef), 64'd1);
            check("R7 zero data", res, '0);
        end

        // R8: output changes only at the capturing edge
        for (int k = 0; k < 32; k++) begin
            d = pattern(k + 9000);
            apply(d, 1'b1, 1'b1, k, 63 - k);
            prev = model(d, 1'b1, k, 63 - k);
            check("R8 due after one edge", res, prev);
            src = ~d; rot = 6'(63 - k); top = 6'(k);
            #1;
            check("R8 held before edge", res, prev);
            @(negedge clk);
            check("R8 next result", res, model(~d, 1'b1, 63 - k, k));
        end

        // R9: reset mid-stream
        apply('1, 1'b1, 1'b1, 0, 63);
        rst = 1'b1;
        @(negedge clk);
        check("R9 res after reset", res, '0);
        check("R9 undef after reset", 64'(undef), 64'd0);
        rst = 1'b0;

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule